// File: doc/BRIEF.md
# Write Request Width Narrower

This block sits between a producer of wide write requests and a consumer that accepts only narrower ones. Each incoming request carries a byte address, a transfer size given as log2 of the byte count, and a data vector as wide as the wide bus. The address is naturally aligned to that size. The narrower turns every wide request into one or more narrow requests on its output and hands them on in address order.

A request that fits within the narrow bus leaves as a single beat. That beat keeps its address and size, and its data is the narrow lane group picked by the address bits above the narrow width. A larger request is broken into consecutive narrow beats. Each beat has the full narrow size, its address is one narrow width above the previous beat, and it takes its data from the next lane group in turn. Both sides use valid/ready handshakes. The block holds one request at a time, so the first beat appears one cycle after the request is accepted. A new request can be accepted in the same cycle that the last beat of the current one is taken.

Top module: `write_narrower`

## Requirements
- R1: During and right after reset, `outValid` is 0 and `inReady` is 1.
- R2: A request whose size field is no larger than log2(NARROW_BYTES) produces exactly one beat. That beat has the request's address and size, and its data is narrow lane group g of the wide data, where g = addr[log2(WIDE_BYTES)-1:log2(NARROW_BYTES)]. Lane group g covers wide data bits [g*NARROW_BYTES*8 +: NARROW_BYTES*8]. Every byte of that group is passed on, including bytes outside the transfer size.
- R3: A request with size s greater than log2(NARROW_BYTES) produces exactly 2^(s - log2(NARROW_BYTES)) beats. Each of these beats carries size log2(NARROW_BYTES).
- R4: For beat k of a split request (k counting from 0), the address is the request address plus k*NARROW_BYTES and the data is lane group g+k. Every output address is aligned to its output size.
- R5: `inReady` is 1 exactly when no request is held, or when the held request's last beat is being taken in this cycle (`outValid` and `outReady` both high). This allows back-to-back requests with no gap cycle.
- R6: While `outValid` is 1 and `outReady` is 0, the next cycle still has `outValid` at 1, and `outAddr`, `outSize` and `outData` are unchanged.
- R7: The first beat of an accepted request is presented with `outValid` high in the cycle after acceptance. `outValid` is 1 exactly while beats of an accepted request remain undelivered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Wide request valid |
| inReady | output | 1 | Wide request accepted when high with inValid |
| inAddr | input | ADDR_W | Wide request byte address, aligned to the size |
| inSize | input | SIZE_W | log2 of the wide request byte count |
| inData | input | WIDE_BYTES*8 | Wide request data, byte i at bits [8i +: 8] |
| outValid | output | 1 | Narrow beat valid |
| outReady | input | 1 | Consumer takes the beat when high with outValid |
| outAddr | output | ADDR_W | Narrow beat byte address |
| outSize | output | SIZE_W | log2 of the narrow beat byte count |
| outData | output | NARROW_BYTES*8 | Narrow beat data |

## Verification
The bench aims at the lane group picked by a small request at an odd byte address. A design that ignored the upper address bits would return group 0 there. It also drives a full-width request and a request exactly two narrow beats wide. A design with a wrong beat count would drop beats, or repeat them past the request, and the bench queue would fall out of step. The bench stalls the consumer at random and keeps offering requests while the last beat is leaving. This exposes beats that change under back-pressure, and an `inReady` that either opens in the middle of a split or misses the back-to-back acceptance.

// File: rtl/wn_pkg.sv
package wn_pkg;

  // Control-to-datapath strobes
  typedef struct packed {
    logic load;   // capture a new wide request, restart beat count
    logic step;   // current beat taken and more beats remain
  } wnStrobe_t;

endpackage

// File: rtl/wn_ctrl.sv
module wn_ctrl
  import wn_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      inValid,
  input  logic      outReady,
  input  logic      lastBeat,
  output logic      inReady,
  output logic      outValid,
  output wnStrobe_t strobe
);

  logic holding;
  logic fire;

  assign fire     = holding & outReady;
  assign outValid = holding;
  assign inReady  = ~holding | (outReady & lastBeat);

  always_comb begin
    strobe      = '0;
    strobe.load = inValid & inReady;
    strobe.step = fire & ~lastBeat;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      holding <= 1'b0;
    end else if (strobe.load) begin
      holding <= 1'b1;
    end else if (fire && lastBeat) begin
      holding <= 1'b0;
    end
  end

  // R5
  no_accept_midsplit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !lastBeat) |-> !inReady);

  // R7
  accept_then_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && inReady) |=> outValid);

endmodule

// File: rtl/wn_datapath.sv
module wn_datapath
  import wn_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int WIDE_BYTES   = 16,
  parameter int NARROW_BYTES = 4,
  parameter int SIZE_W       = $clog2($clog2(WIDE_BYTES) + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  wnStrobe_t                 strobe,
  input  logic [ADDR_W-1:0]         inAddr,
  input  logic [SIZE_W-1:0]         inSize,
  input  logic [WIDE_BYTES*8-1:0]   inData,
  output logic                      lastBeat,
  output logic [ADDR_W-1:0]         outAddr,
  output logic [SIZE_W-1:0]         outSize,
  output logic [NARROW_BYTES*8-1:0] outData
);

  localparam int LOG_W  = $clog2(WIDE_BYTES);
  localparam int LOG_N  = $clog2(NARROW_BYTES);
  localparam int LOG_R  = LOG_W - LOG_N;
  localparam int CNT_W  = LOG_R + 1;
  localparam int GROUPS = WIDE_BYTES / NARROW_BYTES;
  localparam int NBITS  = NARROW_BYTES * 8;

  logic [ADDR_W-1:0]       reqAddr;
  logic [SIZE_W-1:0]       reqSize;
  logic [WIDE_BYTES*8-1:0] reqData;
  logic [CNT_W-1:0]        beatIdx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reqAddr <= '0;
      reqSize <= '0;
      reqData <= '0;
      beatIdx <= '0;
    end else if (strobe.load) begin
      reqAddr <= inAddr;
      reqSize <= inSize;
      reqData <= inData;
      beatIdx <= '0;
    end else if (strobe.step) begin
      beatIdx <= beatIdx + 1'b1;
    end
  end

  logic             isSplit;
  logic [CNT_W-1:0] beatsMinus1;

  assign isSplit = reqSize > SIZE_W'(LOG_N);

  always_comb begin
    beatsMinus1 = '0;
    for (int s = LOG_N + 1; s <= LOG_W; s++) begin
      if (reqSize == SIZE_W'(s)) beatsMinus1 = CNT_W'((1 << (s - LOG_N)) - 1);
    end
  end

  assign lastBeat = (beatIdx == beatsMinus1);

  logic [LOG_R-1:0] baseGroup;
  logic [LOG_R-1:0] curGroup;
  logic [NBITS-1:0] laneGrp [GROUPS];

  assign baseGroup = reqAddr[LOG_W-1:LOG_N];
  assign curGroup  = baseGroup + beatIdx[LOG_R-1:0];

  for (genvar g = 0; g < GROUPS; g++) begin : g_lane
    assign laneGrp[g] = reqData[g*NBITS +: NBITS];
  end

  assign outData = laneGrp[curGroup];
  assign outAddr = reqAddr + (ADDR_W'(beatIdx) << LOG_N);
  assign outSize = isSplit ? SIZE_W'(LOG_N) : reqSize;

  logic [ADDR_W-1:0] alignMask;
  assign alignMask = (ADDR_W'(1) << outSize) - ADDR_W'(1);

  // R3
  beat_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beatIdx <= beatsMinus1);

  // R4
  addr_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (outAddr & alignMask) == '0);

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.step |=> outAddr == $past(outAddr) + ADDR_W'(NARROW_BYTES));

endmodule

// File: rtl/write_narrower.sv
module write_narrower
  import wn_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int WIDE_BYTES   = 16,
  parameter int NARROW_BYTES = 4,
  parameter int SIZE_W       = $clog2($clog2(WIDE_BYTES) + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      inValid,
  output logic                      inReady,
  input  logic [ADDR_W-1:0]         inAddr,
  input  logic [SIZE_W-1:0]         inSize,
  input  logic [WIDE_BYTES*8-1:0]   inData,
  output logic                      outValid,
  input  logic                      outReady,
  output logic [ADDR_W-1:0]         outAddr,
  output logic [SIZE_W-1:0]         outSize,
  output logic [NARROW_BYTES*8-1:0] outData
);

  wnStrobe_t strobe;
  logic      lastBeat;

  wn_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (inValid),
    .outReady (outReady),
    .lastBeat (lastBeat),
    .inReady  (inReady),
    .outValid (outValid),
    .strobe   (strobe)
  );

  wn_datapath #(
    .ADDR_W       (ADDR_W),
    .WIDE_BYTES   (WIDE_BYTES),
    .NARROW_BYTES (NARROW_BYTES),
    .SIZE_W       (SIZE_W)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .inAddr   (inAddr),
    .inSize   (inSize),
    .inData   (inData),
    .lastBeat (lastBeat),
    .outAddr  (outAddr),
    .outSize  (outSize),
    .outData  (outData)
  );

  // R6
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady) |=> (outValid && $stable(outAddr) && $stable(outSize)
                                  && $stable(outData)));

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    $past(!rst_n) |-> (!outValid && inReady));

endmodule

// File: tb/write_narrower_bench.sv
module write_narrower_bench;

  localparam int AW = 32;
  localparam int WB = 16;
  localparam int NB = 4;
  localparam int SW = 3;
  localparam int LOG_N = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          inValid = 1'b0;
  logic          inReady;
  logic [AW-1:0] inAddr = '0;
  logic [SW-1:0] inSize = '0;
  logic [WB*8-1:0] inData = '0;
  logic          outValid;
  logic          outReady = 1'b0;
  logic [AW-1:0] outAddr;
  logic [SW-1:0] outSize;
  logic [NB*8-1:0] outData;

  always #10 clk = ~clk;

  write_narrower u_write_narrower (
    .clk(clk), .rst_n(rst_n),
    .inValid(inValid), .inReady(inReady), .inAddr(inAddr), .inSize(inSize), .inData(inData),
    .outValid(outValid), .outReady(outReady), .outAddr(outAddr), .outSize(outSize),
    .outData(outData)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [AW-1:0]   qAddr [16];
  logic [SW-1:0]   qSize [16];
  logic [NB*8-1:0] qData [16];
  logic            qLast [16];
  logic            qSplit[16];
  int qHead = 0, qTail = 0, qCount = 0;

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pushReq(input logic [AW-1:0] a, input logic [SW-1:0] s,
                         input logic [WB*8-1:0] d);
    int beats;
    int grp;
    beats = (int'(s) > LOG_N) ? (1 << (int'(s) - LOG_N)) : 1;
    grp = int'(a[3:2]);
    for (int k = 0; k < beats; k++) begin
      qAddr[qTail]  = a + AW'(k * NB);
      qSize[qTail]  = (int'(s) > LOG_N) ? SW'(LOG_N) : s;
      qData[qTail]  = d[(grp + k) * 32 +: 32];
      qLast[qTail]  = (k == beats - 1);
      qSplit[qTail] = (beats > 1);
      qTail = (qTail + 1) % 16;
      qCount++;
    end
  endtask

  task automatic directedReq(input int idx);
    inData = {$urandom, $urandom, $urandom, $urandom};
    case (idx)
      0: begin inAddr = 32'h0000_0000; inSize = 3'd4; end
      1: begin inAddr = 32'h0000_000D; inSize = 3'd0; end
      2: begin inAddr = 32'h0000_0208; inSize = 3'd3; end
      3: begin inAddr = 32'h0000_0004; inSize = 3'd2; end
      4: begin inAddr = 32'h0000_0106; inSize = 3'd1; end
      default: begin inAddr = 32'h0000_0040; inSize = 3'd4; end
    endcase
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    bit pending = 0;
    bit prevStall = 0;
    logic [AW-1:0] pAddr;
    logic [SW-1:0] pSize;
    logic [NB*8-1:0] pData;
    int dIdx = 0;
    bit expReady;
    void'($urandom(32'h5EED_1234));
    pAddr = '0; pSize = '0; pData = '0;

    repeat (3) @(negedge clk);
    // R1: idle state held in reset
    check(outValid == 1'b0, "R1 outValid in reset", 128'(outValid), 128'd0);
    check(inReady == 1'b1, "R1 inReady in reset", 128'(inReady), 128'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0, "R1 outValid after reset", 128'(outValid), 128'd0);
    check(inReady == 1'b1, "R1 inReady after reset", 128'(inReady), 128'd1);

    for (int cyc = 0; cyc < 3000; cyc++) begin
      bit drain;
      drain = (cyc >= 2980);
      if (!pending) begin
        if (drain) begin
          inValid = 1'b0;
        end else if (dIdx < 6) begin
          inValid = 1'b1;
          directedReq(dIdx);
        end else begin
          int s;
          inValid = ($urandom % 3) != 0;
          s = $urandom_range(0, 4);
          inSize = SW'(s);
          inAddr = $urandom & (32'hFFFF_FFFF << s);
          inData = {$urandom, $urandom, $urandom, $urandom};
        end
      end
      outReady = (dIdx < 6 || drain) ? 1'b1 : (($urandom % 4) != 0);
      #1;
      // R7: valid exactly while beats are owed
      check(outValid == (qCount != 0), "R7 outValid", 128'(outValid), 128'(qCount != 0));
      // R6: stalled beat is held
      if (prevStall) begin
        check(outValid && outAddr == pAddr && outSize == pSize && outData == pData,
              "R6 held beat", {outAddr, outData}, {pAddr, pData});
      end
      // R5: ready rule
      expReady = (qCount == 0) || (outReady && qLast[qHead]);
      check(inReady == expReady, "R5 inReady", 128'(inReady), 128'(expReady));
      if (outValid && outReady && qCount != 0) begin
        check(outAddr == qAddr[qHead], "R4 beat address", 128'(outAddr), 128'(qAddr[qHead]));
        check(outSize == qSize[qHead], qSplit[qHead] ? "R3 beat size" : "R2 beat size",
              128'(outSize), 128'(qSize[qHead]));
        check(outData == qData[qHead], qSplit[qHead] ? "R4 beat data" : "R2 beat data",
              128'(outData), 128'(qData[qHead]));
        qHead = (qHead + 1) % 16;
        qCount--;
      end
      if (inValid && inReady) begin
        pushReq(inAddr, inSize, inData);
        pending = 0;
        if (dIdx < 6) dIdx++;
      end else begin
        pending = inValid;
      end
      prevStall = outValid && !outReady;
      pAddr = outAddr; pSize = outSize; pData = outData;
      @(negedge clk);
    end
    // R3: every owed beat was delivered, none extra
    check(qCount == 0 && outValid == 1'b0, "R3 all beats drained", 128'(qCount), 128'd0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule